// File: doc/BRIEF.md
# Self-Calibration Request Controller

This block decides when a converter's self-calibration cycle begins and shows when one is in progress. Two request sources feed it: an external calibration pin and a calibration bit that a register bank delivers as a plain level. Both pass through a two-flop synchroniser and are then combined by OR into one request line. Every trigger decision is made on that combined line.

After reset the block waits and then launches one automatic calibration. A wait-select input chooses between a short wait (input low) and a long wait (input high). This input is honoured in every control mode. If the request line is high when the wait ends, the automatic calibration is skipped. A manual calibration needs a qualified sequence on the request line: low for at least a minimum number of cycles, then high for at least a minimum number of cycles.

While a calibration runs, the running output is high for a fixed, configurable number of cycles. Requests that qualify during that time are dropped. All times are counted in clock cycles.

Top module: `cal_req_ctrl`

## Requirements
- R1: The request line is the OR of the synchronised pin and the synchronised register bit. A low phase counts only while both inputs are low.
- R2: `cal_run_o` is low while reset is held and in the first cycle after reset is released.
- R3: With `long_wait_i` low and the request line low, `cal_run_o` rises at the SHORT_WAIT-th rising clock edge after reset is released.
- R4: With `long_wait_i` high and the request line low, the automatic calibration starts at the LONG_WAIT-th edge after reset instead, and not at the short wait.
- R5: Each calibration holds `cal_run_o` high for exactly CAL_LEN cycles. It then returns low and stays low until a new trigger.
- R6: After a qualified low phase, `cal_run_o` rises at the edge where the synchronised line has been high for HIGH_MIN samples. That is HIGH_MIN+2 edges after the input rises.
- R7: A low phase shorter than LOW_MIN cycles (LOW_MIN >= 2) does not arm the trigger. A following high level of any length starts nothing.
- R8: If the line drops before HIGH_MIN high samples, no calibration starts. A fresh low phase of LOW_MIN cycles is then needed, and a one-cycle dip does not satisfy it.
- R9: If the request line is high when the power-on wait ends, the automatic calibration is skipped. A later qualified low-then-high sequence starts a calibration.
- R10: A request that qualifies while a calibration runs is discarded. After that calibration ends, only a new low-then-high sequence starts another.
- R11: A qualified manual request that completes before the power-on wait ends starts a calibration at once and cancels the pending automatic one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_pin_i | input | 1 | External calibration request pin, asynchronous |
| cal_bit_i | input | 1 | Calibration request bit from the register bank |
| long_wait_i | input | 1 | Power-on wait select: 1 selects the long wait, 0 the short wait |
| cal_run_o | output | 1 | High while a calibration is running |

## Verification
The assertions assume that `long_wait_i` holds steady from reset until the power-on wait ends. They also assume LOW_MIN >= 2 and HIGH_MIN >= 1. Under those assumptions, an automatic start always happens with the request line low, and a manual start always happens with it high. The stimulus sets the wait select during reset and never changes it afterwards. All input changes are driven one time unit after a rising edge, so each level spans a whole number of synchronised samples and every hold time is exact to the cycle.

// File: rtl/cal_req_pkg.sv
package cal_req_pkg;
  typedef enum logic [1:0] {
    QS_WAIT_LOW = 2'd0,
    QS_ARMED    = 2'd1,
    QS_HIGH     = 2'd2
  } qual_state_t;
endpackage

// File: rtl/cal_sync2.sv
module cal_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= din;
      stab_q <= meta_q;
    end
  end

  assign dout = stab_q;
endmodule

// File: rtl/cal_req_qual.sv
module cal_req_qual
  import cal_req_pkg::*;
#(
  parameter int LOW_MIN  = 4,
  parameter int HIGH_MIN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic req_s,
  output logic fire
);
  localparam int LW = $clog2(LOW_MIN + 1);
  localparam int HW = $clog2(HIGH_MIN + 1);
  localparam logic [LW-1:0] LOW_LAST  = LW'(LOW_MIN - 1);
  localparam logic [HW-1:0] HIGH_LAST = HW'(HIGH_MIN - 1);

  qual_state_t   st_q;
  logic [LW-1:0] low_q;
  logic [HW-1:0] high_q;

  always_comb begin
    fire = 1'b0;
    if (req_s) begin
      if (st_q == QS_ARMED && HIGH_MIN == 1) fire = 1'b1;
      if (st_q == QS_HIGH && high_q == HIGH_LAST) fire = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= QS_WAIT_LOW;
      low_q  <= '0;
      high_q <= '0;
    end else begin
      case (st_q)
        QS_WAIT_LOW: begin
          if (req_s) begin
            low_q <= '0;
          end else if (low_q == LOW_LAST) begin
            st_q  <= QS_ARMED;
            low_q <= '0;
          end else begin
            low_q <= low_q + 1'b1;
          end
        end
        QS_ARMED: begin
          if (req_s) begin
            if (HIGH_MIN == 1) begin
              st_q <= QS_WAIT_LOW;
            end else begin
              st_q   <= QS_HIGH;
              high_q <= HW'(1);
            end
          end
        end
        QS_HIGH: begin
          if (!req_s) begin
            st_q   <= QS_WAIT_LOW;
            low_q  <= LW'(1);
            high_q <= '0;
          end else if (high_q == HIGH_LAST) begin
            st_q   <= QS_WAIT_LOW;
            low_q  <= '0;
            high_q <= '0;
          end else begin
            high_q <= high_q + 1'b1;
          end
        end
        default: st_q <= QS_WAIT_LOW;
      endcase
    end
  end
endmodule

// File: rtl/cal_por_timer.sv
module cal_por_timer #(
  parameter int SHORT_WAIT = 20,
  parameter int LONG_WAIT  = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic long_sel,
  input  logic req_s,
  input  logic manual_fire,
  output logic por_start,
  output logic por_done
);
  localparam int MAXW = (LONG_WAIT > SHORT_WAIT) ? LONG_WAIT : SHORT_WAIT;
  localparam int CW   = $clog2(MAXW + 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_WAIT - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_WAIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;
  logic          wait_end;

  assign limit     = long_sel ? LONG_LAST : SHORT_LAST;
  assign wait_end  = !por_done && (cnt_q >= limit);
  assign por_start = wait_end && !req_s && !manual_fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      por_done <= 1'b0;
    end else if (!por_done) begin
      if (wait_end || manual_fire) por_done <= 1'b1;
      else                         cnt_q    <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cal_run_seq.sv
module cal_run_seq #(
  parameter int CAL_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic running
);
  localparam int CW = $clog2(CAL_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(CAL_LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt_q   <= '0;
    end else if (!running) begin
      if (start) begin
        running <= 1'b1;
        cnt_q   <= '0;
      end
    end else if (cnt_q == LAST) begin
      running <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cal_req_ctrl.sv
module cal_req_ctrl #(
  parameter int LOW_MIN    = 4,
  parameter int HIGH_MIN   = 3,
  parameter int SHORT_WAIT = 20,
  parameter int LONG_WAIT  = 60,
  parameter int CAL_LEN    = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic cal_pin_i,
  input  logic cal_bit_i,
  input  logic long_wait_i,
  output logic cal_run_o
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] raw_in;
  logic [NSYNC-1:0] sync_out;
  logic             req_s;
  logic             long_s;
  logic             manual_fire;
  logic             por_start;
  logic             por_done;
  logic             running;

  assign raw_in = {long_wait_i, cal_bit_i, cal_pin_i};

  cal_sync2 #(.W(NSYNC)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (raw_in),
    .dout (sync_out)
  );

  assign req_s  = sync_out[0] | sync_out[1];
  assign long_s = sync_out[2];

  cal_req_qual #(.LOW_MIN(LOW_MIN), .HIGH_MIN(HIGH_MIN)) u_qual (
    .clk   (clk),
    .rst   (rst),
    .req_s (req_s),
    .fire  (manual_fire)
  );

  cal_por_timer #(.SHORT_WAIT(SHORT_WAIT), .LONG_WAIT(LONG_WAIT)) u_por (
    .clk         (clk),
    .rst         (rst),
    .long_sel    (long_s),
    .req_s       (req_s),
    .manual_fire (manual_fire),
    .por_start   (por_start),
    .por_done    (por_done)
  );

  cal_run_seq #(.CAL_LEN(CAL_LEN)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (por_start | manual_fire),
    .running (running)
  );

  assign cal_run_o = running;
endmodule

// File: rtl/cal_req_ctrl_chk.sv
module cal_req_ctrl_chk #(
  parameter int HIGH_MIN   = 3,
  parameter int SHORT_WAIT = 20,
  parameter int CAL_LEN    = 16
) (
  input logic clk,
  input logic rst,
  input logic cal_run,
  input logic req_s,
  input logic por_done
);
  localparam int RW = $clog2(CAL_LEN + 2) + 1;
  localparam int HW = $clog2(HIGH_MIN + 2) + 1;

  logic [RW-1:0] run_len;
  logic [HW-1:0] hi_len;
  logic [31:0]   since_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len   <= '0;
      hi_len    <= '0;
      since_rst <= '0;
    end else begin
      run_len <= cal_run ? run_len + 1'b1 : '0;
      if (!req_s)                   hi_len <= '0;
      else if (hi_len < HW'(HIGH_MIN)) hi_len <= hi_len + 1'b1;
      if (since_rst != 32'hFFFF_FFFF) since_rst <= since_rst + 1'b1;
    end
  end

  assert_run_len_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(cal_run) |-> (run_len == RW'(CAL_LEN)));

  assert_start_source_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_run) |-> ($past(req_s) || !$past(por_done)));

  assert_high_hold_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(cal_run) && $past(por_done)) |-> (hi_len >= HW'(HIGH_MIN)));

  assert_por_wait_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(cal_run) && !$past(por_done) && !$past(req_s)) |-> (since_rst >= 32'(SHORT_WAIT)));
endmodule

bind cal_req_ctrl cal_req_ctrl_chk #(
  .HIGH_MIN   (HIGH_MIN),
  .SHORT_WAIT (SHORT_WAIT),
  .CAL_LEN    (CAL_LEN)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cal_run  (cal_run_o),
  .req_s    (req_s),
  .por_done (por_done)
);

// File: tb/cal_req_ctrl_bench.sv
module cal_req_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LOW_MIN    = 4;
  localparam int HIGH_MIN   = 3;
  localparam int SHORT_WAIT = 20;
  localparam int LONG_WAIT  = 60;
  localparam int CAL_LEN    = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin = 1'b0;
  logic rbit = 1'b0;
  logic lsel = 1'b0;
  logic run;

  int n_chk = 0;
  int n_bad = 0;

  cal_req_ctrl #(
    .LOW_MIN(LOW_MIN), .HIGH_MIN(HIGH_MIN), .SHORT_WAIT(SHORT_WAIT),
    .LONG_WAIT(LONG_WAIT), .CAL_LEN(CAL_LEN)
  ) u_cal_req_ctrl (
    .clk(clk), .rst(rst), .cal_pin_i(pin), .cal_bit_i(rbit),
    .long_wait_i(lsel), .cal_run_o(run)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic exp);
    n_chk++;
    if (run !== exp) begin
      n_bad++;
      $display("FAIL %s: cal_run_o actual=%b expected=%b at %0t", tag, run, exp, $time);
    end
  endtask

  task automatic do_reset(input logic p, input logic b, input logic s);
    rst = 1'b1; pin = p; rbit = b; lsel = s;
    step(3);
    chk("R2 during reset", 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_por_short;
    do_reset(1'b0, 1'b0, 1'b0);
    step(1);           chk("R2 after release", 1'b0);
    step(SHORT_WAIT-2); chk("R3 before short wait", 1'b0);
    step(1);           chk("R3 short wait start", 1'b1);
    step(CAL_LEN-1);   chk("R5 last running cycle", 1'b1);
    step(1);           chk("R5 run ended", 1'b0);
    step(40);          chk("R5 stays low", 1'b0);
  endtask

  task automatic t_por_long;
    do_reset(1'b0, 1'b0, 1'b1);
    step(SHORT_WAIT);             chk("R4 no start at short wait", 1'b0);
    step(LONG_WAIT-1-SHORT_WAIT); chk("R4 before long wait", 1'b0);
    step(1);                      chk("R4 long wait start", 1'b1);
    step(CAL_LEN);                chk("R5 long run ended", 1'b0);
  endtask

  task automatic t_bit_trigger;
    do_reset(1'b0, 1'b0, 1'b0);
    step(SHORT_WAIT+CAL_LEN+5); chk("R6 idle", 1'b0);
    rbit = 1'b1;
    step(HIGH_MIN+1); chk("R6 not yet", 1'b0);
    step(1);          chk("R1 R6 bit trigger", 1'b1);
    rbit = 1'b0;
    step(CAL_LEN);    chk("R5 bit run ended", 1'b0);
  endtask

  task automatic t_inhibit;
    do_reset(1'b1, 1'b0, 1'b0);
    step(SHORT_WAIT+CAL_LEN+5); chk("R9 auto skipped", 1'b0);
    pin = 1'b0; rbit = 1'b1;
    step(LOW_MIN+2);
    pin = 1'b1; rbit = 1'b0;
    step(10);   chk("R1 no low phase while one input high", 1'b0);
    pin = 1'b0; step(LOW_MIN-1);
    pin = 1'b1; step(10);
    chk("R7 short low ignored", 1'b0);
    pin = 1'b0; step(LOW_MIN);
    pin = 1'b1; step(HIGH_MIN-1);
    pin = 1'b0; step(1);
    pin = 1'b1; step(10);
    chk("R8 aborted high ignored", 1'b0);
    pin = 1'b0; step(LOW_MIN);
    pin = 1'b1;
    step(HIGH_MIN+1); chk("R9 not yet", 1'b0);
    step(1);          chk("R9 R6 pin trigger after inhibit", 1'b1);
    pin = 1'b0;
    step(CAL_LEN);    chk("R5 run ended", 1'b0);
  endtask

  task automatic t_busy;
    do_reset(1'b0, 1'b0, 1'b0);
    step(SHORT_WAIT); chk("R3 auto running", 1'b1);
    pin = 1'b1;
    step(CAL_LEN+10); chk("R10 request during run dropped", 1'b0);
    pin = 1'b0; step(LOW_MIN);
    pin = 1'b1;
    step(HIGH_MIN+2); chk("R10 fresh sequence starts", 1'b1);
    pin = 1'b0;
    step(CAL_LEN);    chk("R5 run ended", 1'b0);
  endtask

  task automatic t_early;
    do_reset(1'b0, 1'b0, 1'b1);
    step(8);
    pin = 1'b1;
    step(HIGH_MIN+2); chk("R11 early manual start", 1'b1);
    pin = 1'b0;
    step(CAL_LEN);    chk("R11 early run ended", 1'b0);
    step(LONG_WAIT);  chk("R11 auto cancelled", 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: run hung actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_por_short();
    t_por_long();
    t_bit_trigger();
    t_inhibit();
    t_busy();
    t_early();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule